// File: doc/BRIEF.md
# Double-Buffered DAC Register Controller

This block holds the digital state behind a voltage-output converter with a double-buffered code path. A serial front end, which is not part of this block, delivers complete 16-bit command words with a one-cycle valid strobe. The controller keeps a staging code register, a live code register that drives the converter, a shutdown state, a general-purpose logic output bit and an output-shift mode bit. It drives the live code, an output-enable flag and both of those bits to the rest of the chip.

Three board-level pins shape the behaviour. An active-low asynchronous clear forces both code registers to a strap-selected value, either zero or midscale, and drops the logic output bit. A shutdown-allow pin gates every way into shutdown, and its falling edge is one of the ways out. A shutdown pin enters shutdown on its high level. Releasing that pin does not end shutdown. Only a command that loads the live register, or a falling edge on the allow pin, ends it.

Word layout: bits [15:14] hold the opcode and bits [13:2] hold the 12-bit code, most significant bit first. Bits [1:0] are padding. For opcode 11, bits [13:12] select a control action and bit [11] carries its value.

Top module: `dac_regctl`

## Requirements
- R1: Opcode 00 (word[15:14]) writes word[13:2] into the staging register and leaves the live code on `dac_code` unchanged.
- R2: Opcode 01 writes word[13:2] into both registers, so `dac_code` shows it after the next clock edge. Bits [1:0] have no effect.
- R3: Opcode 10 copies the staging register into the live register. The code field of that word is ignored.
- R4: Opcode 11 with action 00 (word[13:12]) changes no register and no output.
- R5: Opcode 11 with action 10 sets `user_bit` to word[11].
- R6: Opcode 11 with action 11 sets `shift_mode` to word[11]. Here 1 is the default mode and 0 the alternate mode.
- R7: Shutdown is entered by opcode 11 with action 01, or by `sd_pin` high. Either way it is entered only while `sd_allow` is high, and it takes effect on the next clock edge.
- R8: Once entered, shutdown persists after `sd_pin` goes low. It ends on opcode 01, on opcode 10, or on a high-to-low transition of `sd_allow` seen at a clock edge. An exit event wins over an entry request in the same cycle.
- R9: During shutdown, `dac_code`, `user_bit` and `shift_mode` keep their values. Opcode 00 still updates the staging register without ending shutdown.
- R10: `clr_n` low immediately sets both code registers to 0x800 when `mid_sel` is high, or to 0 when it is low, and sets `user_bit` to 0. It does not wait for a clock edge.
- R11: Synchronous `rst` applies the same `mid_sel`-based value to both registers. It also clears shutdown, sets `user_bit` to 0 and sets `shift_mode` to 1.
- R12: `out_en` is always the inverse of the shutdown state and changes on the same clock edge as that state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | One-cycle strobe marking a valid command word |
| cmd_word | input | 16 | Decoded command word |
| clr_n | input | 1 | Asynchronous active-low clear |
| mid_sel | input | 1 | Clear/reset level select: 1 midscale, 0 zero |
| sd_allow | input | 1 | High permits shutdown; falling edge exits it |
| sd_pin | input | 1 | High level requests shutdown |
| dac_code | output | 12 | Live converter code |
| out_en | output | 1 | Converter output enabled (low in shutdown) |
| user_bit | output | 1 | Programmable logic output |
| shift_mode | output | 1 | Serial output mode bit (1 default) |

## Verification
The bench builds the block with its default widths, a 12-bit code inside a 16-bit word. With those widths the midscale value 0x800 and the pad-bit and control-field positions line up exactly with the fixed word layout above. Each opcode is exercised, along with clear under both strap levels, entry into shutdown by command and by pin with the allow pin both high and low, and every exit path. A case with the shutdown pin still high at an allow-pin exit shows that level entry stays blocked once the allow pin is low.

// File: rtl/dac_regctl_pkg.sv
package dac_regctl_pkg;

  typedef enum logic [1:0] {
    OP_LOAD_STAGE = 2'b00,
    OP_LOAD_BOTH  = 2'b01,
    OP_COPY       = 2'b10,
    OP_CONTROL    = 2'b11
  } opcode_e;

  typedef enum logic [1:0] {
    ACT_NONE     = 2'b00,
    ACT_SLEEP    = 2'b01,
    ACT_USER_BIT = 2'b10,
    ACT_MODE     = 2'b11
  } action_e;

  typedef struct packed {
    logic stage_wr;
    logic live_from_word;
    logic live_from_stage;
    logic sleep_req;
    logic user_wr;
    logic mode_wr;
    logic value;
  } cmd_act_t;

endpackage

// File: rtl/dac_cmd_decode.sv
module dac_cmd_decode
  import dac_regctl_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int DATA_W = 12
) (
  input  logic              valid,
  input  logic [WORD_W-1:0] word,
  output cmd_act_t          act,
  output logic [DATA_W-1:0] code
);
  localparam int OP_HI   = WORD_W - 1;
  localparam int DATA_HI = WORD_W - 3;
  localparam int DATA_LO = WORD_W - 2 - DATA_W;
  localparam int ACT_HI  = WORD_W - 3;
  localparam int VAL_POS = WORD_W - 5;

  opcode_e op;
  action_e sub;
  logic    unused_pad;

  assign op         = opcode_e'(word[OP_HI -: 2]);
  assign sub        = action_e'(word[ACT_HI -: 2]);
  assign code       = word[DATA_HI:DATA_LO];
  assign unused_pad = ^word;

  always_comb begin
    act       = '0;
    act.value = word[VAL_POS];
    if (valid) begin
      unique case (op)
        OP_LOAD_STAGE: act.stage_wr = 1'b1;
        OP_LOAD_BOTH: begin
          act.stage_wr       = 1'b1;
          act.live_from_word = 1'b1;
        end
        OP_COPY:      act.live_from_stage = 1'b1;
        OP_CONTROL: begin
          unique case (sub)
            ACT_NONE:     ;
            ACT_SLEEP:    act.sleep_req = 1'b1;
            ACT_USER_BIT: act.user_wr   = 1'b1;
            ACT_MODE:     act.mode_wr   = 1'b1;
          endcase
        end
      endcase
    end
  end

  // R4: a control word never touches a code register
  always_comb begin
    if (valid && op == OP_CONTROL)
      a_ctrl_no_load_r4: assert (!act.stage_wr && !act.live_from_word && !act.live_from_stage);
  end

endmodule

// File: rtl/dac_code_regs.sv
module dac_code_regs #(
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_n,
  input  logic              mid_sel,
  input  logic              stage_wr,
  input  logic              live_from_word,
  input  logic              live_from_stage,
  input  logic [DATA_W-1:0] code_in,
  output logic [DATA_W-1:0] live_q
);
  localparam logic [DATA_W-1:0] MIDSCALE = {1'b1, {(DATA_W-1){1'b0}}};

  logic [DATA_W-1:0] stage_q;
  logic [DATA_W-1:0] preset;

  assign preset = mid_sel ? MIDSCALE : '0;

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) begin
      stage_q <= preset;
      live_q  <= preset;
    end else if (rst) begin
      stage_q <= preset;
      live_q  <= preset;
    end else begin
      if (stage_wr)
        stage_q <= code_in;
      if (live_from_word)
        live_q <= code_in;
      else if (live_from_stage)
        live_q <= stage_q;
    end
  end

  // R1: a stage-only write leaves the live code alone
  p_stage_only_r1: assert property (@(posedge clk) disable iff (rst || !clr_n)
    (stage_wr && !live_from_word && !live_from_stage) |=> $stable(live_q));

  // R2: a combined write lands in the live register
  p_both_load_r2: assert property (@(posedge clk) disable iff (rst || !clr_n)
    live_from_word |=> live_q == $past(code_in));

endmodule

// File: rtl/dac_sleep_ctl.sv
module dac_sleep_ctl (
  input  logic clk,
  input  logic rst,
  input  logic sd_allow,
  input  logic sd_pin,
  input  logic sleep_cmd,
  input  logic wake_cmd,
  output logic asleep_q,
  output logic en_q
);
  logic allow_prev;
  logic allow_fall;
  logic enter;
  logic asleep_d;

  assign allow_fall = allow_prev && !sd_allow;
  assign enter      = sd_allow && (sd_pin || sleep_cmd);

  always_comb begin
    asleep_d = asleep_q;
    if (wake_cmd || allow_fall)
      asleep_d = 1'b0;
    else if (enter)
      asleep_d = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      allow_prev <= sd_allow;
      asleep_q   <= 1'b0;
      en_q       <= 1'b1;
    end else begin
      allow_prev <= sd_allow;
      asleep_q   <= asleep_d;
      en_q       <= !asleep_d;
    end
  end

  // R7: shutdown only rises while the allow pin is high
  p_gated_entry_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(asleep_q) |-> $past(sd_allow));

  // R8: a falling allow pin ends shutdown
  p_allow_fall_exit_r8: assert property (@(posedge clk) disable iff (rst)
    (!rst && $fell(sd_allow)) |=> !asleep_q);

  // R8: releasing the pin alone does not wake
  p_pin_release_holds_r8: assert property (@(posedge clk) disable iff (rst)
    (asleep_q && !wake_cmd && sd_allow) |=> asleep_q);

endmodule

// File: rtl/dac_regctl.sv
module dac_regctl
  import dac_regctl_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [WORD_W-1:0] cmd_word,
  input  logic              clr_n,
  input  logic              mid_sel,
  input  logic              sd_allow,
  input  logic              sd_pin,
  output logic [DATA_W-1:0] dac_code,
  output logic              out_en,
  output logic              user_bit,
  output logic              shift_mode
);
  cmd_act_t          act;
  logic [DATA_W-1:0] code;
  logic              asleep;

  dac_cmd_decode #(.WORD_W(WORD_W), .DATA_W(DATA_W)) u_decode (
    .valid (cmd_valid),
    .word  (cmd_word),
    .act   (act),
    .code  (code)
  );

  dac_code_regs #(.DATA_W(DATA_W)) u_regs (
    .clk             (clk),
    .rst             (rst),
    .clr_n           (clr_n),
    .mid_sel         (mid_sel),
    .stage_wr        (act.stage_wr),
    .live_from_word  (act.live_from_word),
    .live_from_stage (act.live_from_stage),
    .code_in         (code),
    .live_q          (dac_code)
  );

  dac_sleep_ctl u_sleep (
    .clk       (clk),
    .rst       (rst),
    .sd_allow  (sd_allow),
    .sd_pin    (sd_pin),
    .sleep_cmd (act.sleep_req),
    .wake_cmd  (act.live_from_word || act.live_from_stage),
    .asleep_q  (asleep),
    .en_q      (out_en)
  );

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n)
      user_bit <= 1'b0;
    else if (rst)
      user_bit <= 1'b0;
    else if (act.user_wr)
      user_bit <= act.value;
  end

  always_ff @(posedge clk) begin
    if (rst)
      shift_mode <= 1'b1;
    else if (act.mode_wr)
      shift_mode <= act.value;
  end

  // R12: enable flag mirrors the shutdown state
  p_en_mirror_r12: assert property (@(posedge clk) disable iff (rst)
    out_en == !asleep);

  // R5: logic output follows its command
  p_user_write_r5: assert property (@(posedge clk) disable iff (rst || !clr_n)
    act.user_wr |=> user_bit == $past(cmd_word[WORD_W-5]));

  // R9: live code held through shutdown when no load arrives
  p_hold_asleep_r9: assert property (@(posedge clk) disable iff (rst || !clr_n)
    (asleep && !act.live_from_word && !act.live_from_stage) |=> $stable(dac_code));

endmodule

// File: tb/dac_regctl_bench.sv
module dac_regctl_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0;
  logic [15:0] cmd_word = '0;
  logic        clr_n = 1'b1;
  logic        mid_sel = 1'b0;
  logic        sd_allow = 1'b1;
  logic        sd_pin = 1'b0;
  logic [11:0] dac_code;
  logic        out_en, user_bit, shift_mode;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  dac_regctl u_dac_regctl (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
    .clr_n(clr_n), .mid_sel(mid_sel), .sd_allow(sd_allow), .sd_pin(sd_pin),
    .dac_code(dac_code), .out_en(out_en), .user_bit(user_bit),
    .shift_mode(shift_mode)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] dw(input logic [1:0] op, input logic [11:0] d,
                                     input logic [1:0] pad);
    return {op, d, pad};
  endfunction

  function automatic logic [15:0] cw(input logic [1:0] act, input logic v);
    return {2'b11, act, v, 11'h000};
  endfunction

  // drive on a falling edge, result visible at the following falling edge
  task automatic send(input logic [15:0] w);
    cmd_word  = w;
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    cmd_word  = '0;
  endtask

  task automatic do_reset(input logic ms);
    mid_sel = ms;
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_reset();
    do_reset(1'b0);
    chk("R11 code zero", dac_code, 0);
    chk("R11 enable", out_en, 1);
    chk("R11 user", user_bit, 0);
    chk("R11 mode", shift_mode, 1);
    do_reset(1'b1);
    chk("R11 code mid", dac_code, 12'h800);
  endtask

  task automatic t_loads();
    send(dw(2'b00, 12'hABC, 2'b00));
    chk("R1 live unchanged", dac_code, 12'h800);
    send(dw(2'b10, 12'h111, 2'b11));
    chk("R3 copy staged", dac_code, 12'hABC);
    send(dw(2'b01, 12'h123, 2'b11));
    chk("R2 both load pad ignored", dac_code, 12'h123);
    send(dw(2'b01, 12'hFFF, 2'b10));
    chk("R2 full scale", dac_code, 12'hFFF);
    send(dw(2'b10, 12'h000, 2'b00));
    chk("R2 staged copy of both-load", dac_code, 12'hFFF);
  endtask

  task automatic t_nop();
    send(cw(2'b00, 1'b1));
    chk("R4 nop code", dac_code, 12'hFFF);
    chk("R4 nop user", user_bit, 0);
    chk("R4 nop mode", shift_mode, 1);
    chk("R4 nop enable", out_en, 1);
  endtask

  task automatic t_user_mode();
    send(cw(2'b10, 1'b1));
    chk("R5 user high", user_bit, 1);
    send(cw(2'b11, 1'b0));
    chk("R6 mode alternate", shift_mode, 0);
    chk("R6 user kept", user_bit, 1);
    send(cw(2'b11, 1'b1));
    chk("R6 mode default", shift_mode, 1);
    send(cw(2'b10, 1'b0));
    chk("R5 user low", user_bit, 0);
  endtask

  task automatic t_cmd_sleep();
    send(cw(2'b10, 1'b1));
    send(cw(2'b01, 1'b0));
    chk("R7 R12 cmd sleep", out_en, 0);
    send(dw(2'b00, 12'h456, 2'b00));
    chk("R9 still asleep after stage load", out_en, 0);
    chk("R9 code held", dac_code, 12'hFFF);
    chk("R9 user held", user_bit, 1);
    send(dw(2'b10, 12'h000, 2'b00));
    chk("R8 copy wakes", out_en, 1);
    chk("R8 copy brings staged", dac_code, 12'h456);
    send(cw(2'b01, 1'b0));
    send(dw(2'b01, 12'h321, 2'b00));
    chk("R8 both-load wakes", out_en, 1);
    chk("R8 both-load code", dac_code, 12'h321);
    sd_allow = 1'b0;
    @(negedge clk);
    send(cw(2'b01, 1'b0));
    chk("R7 locked cmd ignored", out_en, 1);
    sd_allow = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_pin_sleep();
    sd_pin = 1'b1;
    @(negedge clk);
    chk("R7 pin sleep", out_en, 0);
    sd_pin = 1'b0;
    repeat (3) @(negedge clk);
    chk("R8 pin release holds", out_en, 0);
    sd_allow = 1'b0;
    @(negedge clk);
    chk("R8 allow fall wakes", out_en, 1);
    sd_pin = 1'b1;
    repeat (2) @(negedge clk);
    chk("R7 locked pin ignored", out_en, 1);
    sd_allow = 1'b1;
    @(negedge clk);
    chk("R7 pin level re-enters", out_en, 0);
    sd_pin = 1'b0;
    sd_allow = 1'b0;
    @(negedge clk);
    sd_allow = 1'b1;
    @(negedge clk);
    chk("R12 enable back", out_en, 1);
  endtask

  task automatic t_clear();
    mid_sel = 1'b1;
    send(cw(2'b10, 1'b1));
    #3 clr_n = 1'b0;
    #2;
    chk("R10 async mid", dac_code, 12'h800);
    chk("R10 user cleared", user_bit, 0);
    @(negedge clk);
    clr_n = 1'b1;
    send(dw(2'b01, 12'h0F0, 2'b00));
    send(dw(2'b10, 12'h000, 2'b00));
    chk("R10 staging untouched before clear", dac_code, 12'h0F0);
    mid_sel = 1'b0;
    #3 clr_n = 1'b0;
    #2;
    chk("R10 async zero", dac_code, 0);
    @(negedge clk);
    clr_n = 1'b1;
    send(dw(2'b10, 12'h000, 2'b00));
    chk("R10 staging also cleared", dac_code, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_loads();
    t_nop();
    t_user_mode();
    t_cmd_sleep();
    t_pin_sleep();
    t_clear();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule